// File: doc/BRIEF.md
# Frozen Cross-Domain Register Synchronizer

This block carries configuration register writes from a fast bus clock domain into a slow counting clock domain. Each write lands first in a shadow register on the bus side. The shadow contents then move across on a toggle request and acknowledge handshake. Each direction of that handshake passes through a two-flop synchronizer. While a write is travelling, the matching bit of a per-register busy vector stays high. Software can poll that bit to learn when the slow side holds the new value.

A freeze input lets software stage several writes at once. While freeze is high, no new transfer starts and the written values wait in the shadow registers. When freeze drops, every register that was modified is sent in one transfer. The slow side loads all of them on the same slow clock edge. If a transfer is already in flight when freeze rises, that transfer still finishes. Rewriting a value the register already holds still counts as a modification and is transferred.

Top module: `frozen_reg_xfer`

## Requirements
- R1: After reset, the busy vector is all zero and every slow-domain register reads zero.
- R2: A write with `wr_en` high and `wr_addr` equal to i (i below NREG) sets `busy[i]` on the bus clock edge that samples the write.
- R3: A write to an address of NREG or above has no effect: the busy vector stays zero and no slow-domain register changes.
- R4: While `freeze` is high, no new transfer starts. Written registers keep their busy bits set, and the slow-domain registers keep their values.
- R5: When `freeze` falls, all registers written during the freeze change in the slow domain on one and the same slow clock edge.
- R6: Raising `freeze` does not abort a transfer already in progress. That transfer completes and its busy bits clear while `freeze` stays high.
- R7: Writing a value equal to the one a register already holds still sets its busy bit and runs a full transfer, which then clears the bit. The slow-domain value stays the same.
- R8: A write to a register that is already busy replaces its shadow value. The most recent value reaches the slow domain, and no value is delivered out of order.
- R9: A busy bit clears only after the acknowledge for its transfer has returned. Once the whole busy vector reads zero, the slow-domain registers hold the last written values.
- R10: A transfer loads only the registers that were modified. Slice i of `slow_regs` (bits i*DW upward) belongs to address i, and the other slices keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus-domain clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_addr | input | ADDR_W | Register index of the write |
| wr_data | input | DW | Write data |
| freeze | input | 1 | Hold new transfers while high; release them together when it falls |
| busy | output | NREG | Per-register busy bit: write pending or in flight |
| slow_clk | input | 1 | Slow counting-domain clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| slow_regs | output | NREG*DW | Slow-domain register values, register i in slice i |

## Verification
The hardest case to reach from the ports is the overlap of a new write, or a rising freeze, with a transfer that has already left the bus domain. A write or freeze change that lands one cycle too early merges into the pending set instead of overlapping the transfer. The stimulus therefore waits exactly two bus cycles after a write, so the launch edge has passed. Only then does it raise freeze or write the same register again. This lets the bench predict that two separate deliveries happen, in write order. The whole sequence is repeated with slow clocks slower and faster than the bus clock, at unrelated ratios. A scoreboard compares every change of the full slow-domain vector against the queue of expected snapshots, so a batch that lands on two different edges shows up as a mismatch.

// File: rtl/fzsync_pkg.sv
package fzsync_pkg;

    // Default geometry: control, command and top-buffer slots.
    localparam int DEF_NREG   = 3;
    localparam int DEF_DW     = 16;
    localparam int DEF_ADDR_W = 2;
    localparam int DEF_STAGES = 2;

    // Symbolic slot indices for the default register set.
    typedef enum int {
        SLOT_CTRL = 0,
        SLOT_CMD  = 1,
        SLOT_TOPB = 2
    } slot_e;

    // Bus-side per-register progress.
    typedef struct packed {
        logic pend;  // written, waiting for launch
        logic fly;   // launched, waiting for acknowledge
    } slot_state_t;

    // Address decode helper: true when addr selects slot idx of n.
    function automatic logic slot_hit(input int addr, input int idx, input int n);
        return (addr == idx) && (idx < n);
    endfunction

endpackage

// File: rtl/fz_sync_bit.sv
module fz_sync_bit #(
    parameter int STAGES = fzsync_pkg::DEF_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fz_bus_side.sv
module fz_bus_side
    import fzsync_pkg::*;
#(
    parameter int NREG   = DEF_NREG,
    parameter int DW     = DEF_DW,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic                 freeze,
    input  logic                 ack_sync,
    output logic                 req_tgl,
    output logic [NREG*DW-1:0]   xfer_data,
    output logic [NREG-1:0]      xfer_mask,
    output logic [NREG-1:0]      busy_o
);
    localparam int TOTAL_W = NREG * DW;

    slot_state_t [NREG-1:0] st_q, st_d;
    logic [NREG-1:0]  wr_hit;
    logic [NREG-1:0]  pend_vec, fly_vec;
    logic [TOTAL_W-1:0] shadow;
    logic             xfer_done, launch;

    // Address decode and per-slot shadow storage
    generate
        for (genvar i = 0; i < NREG; i++) begin : g_slot
            assign wr_hit[i]   = wr_en && slot_hit(int'(wr_addr), i, NREG);
            assign pend_vec[i] = st_q[i].pend;
            assign fly_vec[i]  = st_q[i].fly;
            assign busy_o[i]   = st_q[i].pend | st_q[i].fly;

            always_ff @(posedge clk) begin
                if (rst)            shadow[i*DW +: DW] <= '0;
                else if (wr_hit[i]) shadow[i*DW +: DW] <= wr_data;
            end

            // R2: an accepted write shows as busy on the next cycle
            p_wr_sets_busy_r2: assert property (@(posedge clk) disable iff (rst)
                wr_hit[i] |=> busy_o[i]);

            // R9: busy only drops when the acknowledge came back
            p_busy_clear_on_ack_r9: assert property (@(posedge clk) disable iff (rst)
                $fell(busy_o[i]) |-> $past(xfer_done));
        end
    endgenerate

    // Handshake control
    assign xfer_done = (|fly_vec) && (ack_sync == req_tgl);
    assign launch    = (fly_vec == '0) && !freeze && (|pend_vec);

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            st_d[i].pend = (launch ? 1'b0 : st_q[i].pend) | wr_hit[i];
            if (launch)
                st_d[i].fly = st_q[i].pend;
            else if (xfer_done)
                st_d[i].fly = 1'b0;
            else
                st_d[i].fly = st_q[i].fly;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            req_tgl   <= 1'b0;
            xfer_data <= '0;
            xfer_mask <= '0;
        end else begin
            st_q <= st_d;
            if (launch) begin
                req_tgl   <= ~req_tgl;
                xfer_data <= shadow;
                xfer_mask <= pend_vec;
            end
        end
    end

    // R3: an out-of-range write leaves an idle block idle
    p_bad_addr_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ({1'b0, wr_addr} >= (ADDR_W+1)'(NREG)) && busy_o == '0) |=> busy_o == '0);

    // R4: no request leaves while freeze is high
    p_no_launch_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        $changed(req_tgl) |-> $past(!freeze));

    // R9: at most one transfer in flight at a time
    p_single_flight_r9: assert property (@(posedge clk) disable iff (rst)
        $changed(req_tgl) |-> $past(fly_vec == '0));
endmodule

// File: rtl/fz_slow_side.sv
module fz_slow_side
    import fzsync_pkg::*;
#(
    parameter int NREG = DEF_NREG,
    parameter int DW   = DEF_DW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_sync,
    input  logic [NREG*DW-1:0] xfer_data,
    input  logic [NREG-1:0]    xfer_mask,
    output logic               ack_tgl,
    output logic [NREG*DW-1:0] regs_o
);
    logic req_seen;
    logic evt;

    assign evt = req_sync ^ req_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_seen <= 1'b0;
            ack_tgl  <= 1'b0;
        end else begin
            req_seen <= req_sync;
            if (evt) ack_tgl <= req_sync;
        end
    end

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_load
            always_ff @(posedge clk) begin
                if (rst)
                    regs_o[i*DW +: DW] <= '0;
                else if (evt && xfer_mask[i])
                    regs_o[i*DW +: DW] <= xfer_data[i*DW +: DW];
            end

            // R10: slots outside the transfer mask hold their value
            p_unmasked_hold_r10: assert property (@(posedge clk) disable iff (rst)
                (evt && !xfer_mask[i]) |=> $stable(regs_o[i*DW +: DW]));
        end
    endgenerate

    // R4: slow registers change only on a request event
    p_no_spurious_load_r4: assert property (@(posedge clk) disable iff (rst)
        !evt |=> $stable(regs_o));

    // R9: acknowledge follows the request it answers
    p_ack_tracks_req_r9: assert property (@(posedge clk) disable iff (rst)
        evt |=> (ack_tgl == $past(req_sync)));
endmodule

// File: rtl/frozen_reg_xfer.sv
module frozen_reg_xfer
    import fzsync_pkg::*;
#(
    parameter int NREG   = DEF_NREG,
    parameter int DW     = DEF_DW,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int STAGES = DEF_STAGES
) (
    input  logic               bus_clk,
    input  logic               bus_rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic               freeze,
    output logic [NREG-1:0]    busy,
    input  logic               slow_clk,
    input  logic               slow_rst,
    output logic [NREG*DW-1:0] slow_regs
);
    logic               req_tgl, req_sync, ack_tgl, ack_sync;
    logic [NREG*DW-1:0] xfer_data;
    logic [NREG-1:0]    xfer_mask;

    fz_bus_side #(.NREG(NREG), .DW(DW), .ADDR_W(ADDR_W)) u_bus (
        .clk(bus_clk), .rst(bus_rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .freeze(freeze), .ack_sync(ack_sync),
        .req_tgl(req_tgl), .xfer_data(xfer_data), .xfer_mask(xfer_mask),
        .busy_o(busy)
    );

    fz_sync_bit #(.STAGES(STAGES)) u_req_sync (
        .clk(slow_clk), .rst(slow_rst), .d(req_tgl), .q(req_sync)
    );

    fz_sync_bit #(.STAGES(STAGES)) u_ack_sync (
        .clk(bus_clk), .rst(bus_rst), .d(ack_tgl), .q(ack_sync)
    );

    fz_slow_side #(.NREG(NREG), .DW(DW)) u_slow (
        .clk(slow_clk), .rst(slow_rst),
        .req_sync(req_sync), .xfer_data(xfer_data), .xfer_mask(xfer_mask),
        .ack_tgl(ack_tgl), .regs_o(slow_regs)
    );
endmodule

// File: tb/tb_frozen_reg_xfer.sv
`timescale 1ns/1ps
module tb_frozen_reg_xfer;
    localparam int  NREG = 3;
    localparam int  DW   = 16;
    localparam int  AW   = 2;
    localparam int  TW   = NREG * DW;
    localparam real CLK_PERIOD = 10.0;

    logic bus_clk = 1'b0, slow_clk = 1'b0;
    logic bus_rst = 1'b1, slow_rst = 1'b1;
    logic wr_en = 1'b0, freeze = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NREG-1:0] busy;
    logic [TW-1:0] slow_regs;

    real slow_half = 17.0;
    int  n_checks = 0, n_fail = 0;
    bit  mon_en = 0, done = 0;
    logic [TW-1:0] model, mon_prev;
    logic [TW-1:0] exp_q[$];

    frozen_reg_xfer #(.NREG(NREG), .DW(DW), .ADDR_W(AW)) dut (
        .bus_clk(bus_clk), .bus_rst(bus_rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .freeze(freeze), .busy(busy), .slow_clk(slow_clk),
        .slow_rst(slow_rst), .slow_regs(slow_regs)
    );

    always #(CLK_PERIOD/2.0) bus_clk = ~bus_clk;
    always #(slow_half) slow_clk = ~slow_clk;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every change of the slow vector must match the next snapshot
    always @(negedge slow_clk) begin
        if (mon_en && !slow_rst && slow_regs !== mon_prev) begin
            if (exp_q.size() == 0)
                check(0, "R10 unexpected slow update", 64'(slow_regs), 64'(mon_prev));
            else begin
                logic [TW-1:0] e;
                e = exp_q.pop_front();
                check(slow_regs === e, "R5 slow vector update", 64'(slow_regs), 64'(e));
            end
            mon_prev = slow_regs;
        end
    end

    task automatic bus_write(input int a, input logic [DW-1:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
        if (a < NREG) model[a*DW +: DW] = d;
    endtask

    task automatic wait_busy_clear(input logic [NREG-1:0] m, input string tag);
        int n = 0;
        while ((busy & m) != '0 && n < 4000) begin
            @(negedge bus_clk);
            n++;
        end
        check((busy & m) == '0, tag, 64'(busy), 64'(0));
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge slow_clk);
        @(negedge bus_clk);
    endtask

    task automatic do_reset();
        mon_en = 0;
        bus_rst = 1'b1; slow_rst = 1'b1; freeze = 1'b0; wr_en = 1'b0;
        repeat (6) @(negedge slow_clk);
        repeat (6) @(negedge bus_clk);
        slow_rst = 1'b0;
        @(negedge bus_clk);
        bus_rst = 1'b0;
        model = '0; mon_prev = '0; exp_q.delete();
        mon_en = 1;
        @(negedge bus_clk);
    endtask

    task automatic run_pass();
        logic [TW-1:0] held;
        do_reset();
        // R1: reset state
        check(busy == '0, "R1 busy after reset", 64'(busy), 64'(0));
        check(slow_regs == '0, "R1 slow regs after reset", 64'(slow_regs), 64'(0));

        // R2, R9: single write per slot
        bus_write(0, 16'hA001);
        check(busy[0] == 1'b1, "R2 busy after write", 64'(busy), 64'(1));
        exp_q.push_back(model);
        wait_busy_clear('1, "R9 busy clears");
        check(slow_regs == model, "R9 value at idle", 64'(slow_regs), 64'(model));
        bus_write(2, 16'h7E55);
        check(busy == 3'b100, "R2 busy slot 2", 64'(busy), 64'(3'b100));
        exp_q.push_back(model);
        wait_busy_clear('1, "R9 busy clears slot 2");
        bus_write(1, 16'h0C3C);
        exp_q.push_back(model);
        wait_busy_clear('1, "R9 busy clears slot 1");
        check(slow_regs[0 +: DW] == 16'hA001 && slow_regs[2*DW +: DW] == 16'h7E55,
              "R10 other slots kept", 64'(slow_regs), 64'(model));

        // R3: out-of-range address
        held = slow_regs;
        bus_write(3, 16'hDEAD);
        check(busy == '0, "R3 bad address busy", 64'(busy), 64'(0));
        idle_cycles(8);
        check(slow_regs == held, "R3 bad address no change", 64'(slow_regs), 64'(held));

        // R4, R5: batched update under freeze
        held = slow_regs;
        @(negedge bus_clk) freeze = 1'b1;
        bus_write(0, 16'h1111);
        bus_write(1, 16'h2222);
        bus_write(2, 16'h3333);
        idle_cycles(20);
        check(busy == 3'b111, "R4 busy held under freeze", 64'(busy), 64'(3'b111));
        check(slow_regs == held, "R4 slow hold under freeze", 64'(slow_regs), 64'(held));
        exp_q.push_back(model);
        @(negedge bus_clk) freeze = 1'b0;
        wait_busy_clear('1, "R5 batch completes");
        check(slow_regs == model, "R5 batch landed", 64'(slow_regs), 64'(model));

        // R6: freeze raised after launch lets the transfer finish
        bus_write(1, 16'h4B4B);
        exp_q.push_back(model);
        @(negedge bus_clk);
        freeze = 1'b1;
        wait_busy_clear(3'b010, "R6 in-flight finishes under freeze");
        check(slow_regs == model, "R6 value delivered", 64'(slow_regs), 64'(model));
        held = slow_regs;
        bus_write(0, 16'h5A5A);
        idle_cycles(12);
        check(busy[0] == 1'b1 && slow_regs == held, "R4 second write held",
              64'(slow_regs), 64'(held));
        exp_q.push_back(model);
        @(negedge bus_clk) freeze = 1'b0;
        wait_busy_clear('1, "R9 idle after release");

        // R7: same-value rewrite still synchronizes
        held = slow_regs;
        bus_write(2, model[2*DW +: DW]);
        check(busy[2] == 1'b1, "R7 busy on same value", 64'(busy), 64'(3'b100));
        wait_busy_clear('1, "R7 busy clears");
        idle_cycles(4);
        check(slow_regs == held, "R7 value unchanged", 64'(slow_regs), 64'(held));

        // R8: overwrite while in flight gives two ordered deliveries
        bus_write(0, 16'h9001);
        exp_q.push_back(model);
        @(negedge bus_clk);
        bus_write(0, 16'h9002);
        check(busy[0] == 1'b1, "R8 busy after overwrite", 64'(busy), 64'(1));
        exp_q.push_back(model);
        wait_busy_clear('1, "R8 busy clears");
        check(slow_regs == model, "R8 latest delivered", 64'(slow_regs), 64'(model));

        // R8: overwrite while pending under freeze collapses to one delivery
        @(negedge bus_clk) freeze = 1'b1;
        bus_write(1, 16'hB0B0);
        bus_write(1, 16'hB1B1);
        exp_q.push_back(model);
        @(negedge bus_clk) freeze = 1'b0;
        wait_busy_clear('1, "R8 pending overwrite clears");
        idle_cycles(4);
        check(slow_regs == model, "R8 pending latest", 64'(slow_regs), 64'(model));
        check(exp_q.size() == 0, "R5 scoreboard drained", 64'(exp_q.size()), 64'(0));
    endtask

    initial begin
        slow_half = 17.0;  run_pass();
        slow_half = 43.0;  run_pass();
        slow_half = 3.7;   run_pass();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000.0);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule